// File: doc/BRIEF.md
# Half-Bridge Bias Ramp Sequencer

This block sequences one channel pair of a class-D power stage through a slow ramp of its output bias when the outputs drive loads through DC-blocking capacitors. When the pair is released from reset, the bias level climbs from ground to mid-supply. Only after it arrives at mid-supply are the power switches allowed to follow the PWM input. When the pair is put back into reset, switching stops and the level falls back to ground. The outputs go to high impedance only once ground is reached. This keeps the coupling capacitor from being charged or discharged in one step, so no pop is heard.

The level is a digital code for an external DAC or duty generator. The block also drives a switching-enable flag and a high-impedance flag. A free-running rate tick paces the ramp. Rising steps and falling steps use separate tick dividers because the discharge is meant to be far slower than the charge. Ramping applies only in the quad half-bridge configuration. In every other configuration, and whenever the ramp enable is low, reset release and reset assertion act at once.

Top module: `hb_bias_ramp_seq`

## Requirements
- R1: While `rst_n` is low, `out_hiz` is 1, `sw_en` is 0 and `ramp_level` is 0.
- R2: With ramping in effect, releasing `pair_rst_n` clears `out_hiz` on the next clock edge and starts the level at 0. The level rises to 512, and `sw_en` stays 0 until the edge on which the level reaches 512, where it becomes 1.
- R3: With ramping in effect, asserting `pair_rst_n` low clears `sw_en` on the next edge. The level then falls from its present value to 0, and `out_hiz` becomes 1 only on the edge where the level reaches 0.
- R4: With ramping not in effect, `pair_rst_n` low gives `out_hiz`=1 and level 0 on the next edge. `pair_rst_n` high gives `sw_en`=1 and level 512 on the next edge.
- R5: A reversal of `pair_rst_n` during a ramp changes the direction on the next edge. The level continues from its present value and does not restart.
- R6: Ramping is in effect only when `ramp_en` is 1 and `mode_code` is 3'b011 or 3'b111 (quad half-bridge). Every other code acts as if `ramp_en` were 0.
- R7: A rising step of one code happens once every `UP_TICKS` rate ticks, and a falling step once every `DN_TICKS` rate ticks. The dividers restart on entry to each ramp, and the level holds while no tick arrives.
- R8: If ramping goes out of effect during a rise, the pair goes to switching at level 512 on the next edge. If it goes out of effect during a fall, the outputs go to high impedance at level 0 on the next edge.
- R9: `ramp_level` never exceeds 512, and `sw_en` is 1 only at level 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pair_rst_n | input | 1 | Active-low reset of the channel pair |
| ramp_en | input | 1 | Request for soft bias ramping |
| mode_code | input | 3 | Output configuration code |
| rate_tick | input | 1 | One-cycle pulse pacing the ramp |
| ramp_level | output | 10 | Bias level code, 512 = mid-supply |
| sw_en | output | 1 | Power switches follow the PWM input |
| out_hiz | output | 1 | Outputs at high impedance |

## Verification
The hardest case to reach is a reversal in the middle of a ramp. The level must be strictly between 0 and 512, and the divider of the new direction must start from zero. The stimulus first holds the rate tick low so the rise pauses at a known level. It then counts ticks to reach level 100 exactly, turns the ramp down for a counted number of ticks, and turns it up again. The bench predicts every level as start plus or minus the tick count divided by the step divisor. A second reversal one cycle after release, at level 0, exercises the empty down-ramp path.

// File: rtl/hb_ramp_pkg.sv
package hb_ramp_pkg;

  typedef enum logic [1:0] {
    ST_OFF_HIZ = 2'd0,
    ST_RAMP_UP = 2'd1,
    ST_RUN     = 2'd2,
    ST_RAMP_DN = 2'd3
  } ramp_st_e;

  // Quad half-bridge configuration: both the plain and the inverted variant.
  function automatic logic is_quad_hb(input logic [2:0] code);
    return (code == 3'b011) || (code == 3'b111);
  endfunction

endpackage

// File: rtl/hb_mode_gate.sv
module hb_mode_gate (
  input  logic [2:0] mode_code,
  input  logic       ramp_en,
  output logic       quad_mode,
  output logic       ramp_ok
);
  import hb_ramp_pkg::*;

  assign quad_mode = is_quad_hb(mode_code);
  assign ramp_ok   = ramp_en & quad_mode;
endmodule

// File: rtl/hb_step_div.sv
module hb_step_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic step
);
  generate
    if (DIV <= 1) begin : g_direct
      assign step = active & tick;
      assert_direct_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> active);
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!active) cnt <= '0;
        else if (tick)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      assign step = active & tick & (cnt == LAST);

      // With a divisor of two or more, two steps can never be adjacent.
      assert_step_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
    end
  endgenerate
endmodule

// File: rtl/hb_ramp_fsm.sv
module hb_ramp_fsm #(
  parameter int unsigned LEVEL_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pair_rst_n,
  input  logic               ramp_ok,
  input  logic               up_step,
  input  logic               dn_step,
  output logic [LEVEL_W-1:0] level,
  output logic               up_active,
  output logic               dn_active,
  output logic               sw_en,
  output logic               out_hiz
);
  import hb_ramp_pkg::*;

  localparam logic [LEVEL_W-1:0] MID = LEVEL_W'(1) << (LEVEL_W - 1);
  localparam logic [LEVEL_W-1:0] ONE = LEVEL_W'(1);

  ramp_st_e           st, nxt_st;
  logic [LEVEL_W-1:0] nxt_lvl;

  function automatic logic [LEVEL_W-1:0] inc_lvl(input logic [LEVEL_W-1:0] v);
    return (v >= MID) ? MID : v + ONE;
  endfunction

  function automatic logic [LEVEL_W-1:0] dec_lvl(input logic [LEVEL_W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  always_comb begin
    nxt_st  = st;
    nxt_lvl = level;
    unique case (st)
      ST_OFF_HIZ: begin
        if (pair_rst_n) begin
          if (ramp_ok) begin
            nxt_st  = ST_RAMP_UP;
            nxt_lvl = '0;
          end else begin
            nxt_st  = ST_RUN;
            nxt_lvl = MID;
          end
        end
      end
      ST_RAMP_UP: begin
        if (!pair_rst_n) begin
          if (ramp_ok) nxt_st = ST_RAMP_DN;
          else begin
            nxt_st  = ST_OFF_HIZ;
            nxt_lvl = '0;
          end
        end else if (!ramp_ok || level >= MID) begin
          nxt_st  = ST_RUN;
          nxt_lvl = MID;
        end else if (up_step) begin
          nxt_lvl = inc_lvl(level);
          if (inc_lvl(level) == MID) nxt_st = ST_RUN;
        end
      end
      ST_RUN: begin
        nxt_lvl = MID;
        if (!pair_rst_n) begin
          if (ramp_ok) nxt_st = ST_RAMP_DN;
          else begin
            nxt_st  = ST_OFF_HIZ;
            nxt_lvl = '0;
          end
        end
      end
      ST_RAMP_DN: begin
        if (pair_rst_n) begin
          if (ramp_ok) nxt_st = ST_RAMP_UP;
          else begin
            nxt_st  = ST_RUN;
            nxt_lvl = MID;
          end
        end else if (!ramp_ok || level == '0) begin
          nxt_st  = ST_OFF_HIZ;
          nxt_lvl = '0;
        end else if (dn_step) begin
          nxt_lvl = dec_lvl(level);
          if (level == ONE) nxt_st = ST_OFF_HIZ;
        end
      end
      default: begin
        nxt_st  = ST_OFF_HIZ;
        nxt_lvl = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_OFF_HIZ;
      level <= '0;
    end else begin
      st    <= nxt_st;
      level <= nxt_lvl;
    end
  end

  assign up_active = (st == ST_RAMP_UP);
  assign dn_active = (st == ST_RAMP_DN);
  assign sw_en     = (st == ST_RUN);
  assign out_hiz   = (st == ST_OFF_HIZ);

  assert_sw_at_bias_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> level == MID);
  assert_level_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    level <= MID);
  assert_fall_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_active && !pair_rst_n && ramp_ok) |=> level <= $past(level));
  assert_hiz_only_at_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_active && !pair_rst_n && ramp_ok && level > ONE) |=> !out_hiz);
  assert_noramp_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_ok && !pair_rst_n) |=> out_hiz && level == '0);
  assert_noramp_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_ok && pair_rst_n) |=> sw_en);
  assert_reverse_keeps_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_active && pair_rst_n && ramp_ok) |=> up_active && level == $past(level));
  assert_rise_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_active && pair_rst_n && ramp_ok && !up_step && level < MID) |=> level == $past(level));
endmodule

// File: rtl/hb_bias_ramp_seq.sv
module hb_bias_ramp_seq #(
  parameter int unsigned LEVEL_W  = 10,
  parameter int unsigned UP_TICKS = 2,
  parameter int unsigned DN_TICKS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pair_rst_n,
  input  logic               ramp_en,
  input  logic [2:0]         mode_code,
  input  logic               rate_tick,
  output logic [LEVEL_W-1:0] ramp_level,
  output logic               sw_en,
  output logic               out_hiz
);
  logic quad_mode, ramp_ok;
  logic up_active, dn_active, up_step, dn_step;

  hb_mode_gate u_gate (
    .mode_code (mode_code),
    .ramp_en   (ramp_en),
    .quad_mode (quad_mode),
    .ramp_ok   (ramp_ok)
  );

  hb_step_div #(.DIV(UP_TICKS)) u_up_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (up_active),
    .tick   (rate_tick),
    .step   (up_step)
  );

  hb_step_div #(.DIV(DN_TICKS)) u_dn_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (dn_active),
    .tick   (rate_tick),
    .step   (dn_step)
  );

  hb_ramp_fsm #(.LEVEL_W(LEVEL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_rst_n (pair_rst_n),
    .ramp_ok    (ramp_ok),
    .up_step    (up_step),
    .dn_step    (dn_step),
    .level      (ramp_level),
    .up_active  (up_active),
    .dn_active  (dn_active),
    .sw_en      (sw_en),
    .out_hiz    (out_hiz)
  );

  // Outside quad half-bridge a parked pair goes straight to switching on release.
  assert_mode_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad_mode && pair_rst_n && out_hiz) |=> sw_en);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && out_hiz));
endmodule

// File: tb/hb_bias_ramp_seq_tb.sv
module hb_bias_ramp_seq_tb;
  localparam int UP  = 2;
  localparam int DN  = 6;
  localparam int MID = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pair_rst_n = 1'b0;
  logic       ramp_en = 1'b0;
  logic [2:0] mode_code = 3'd3;
  logic       rate_tick = 1'b0;
  logic [9:0] ramp_level;
  logic       sw_en, out_hiz;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    lvl;
    bit    sw;
    bit    hz;
    string tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  hb_bias_ramp_seq #(.LEVEL_W(10), .UP_TICKS(UP), .DN_TICKS(DN)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_rst_n (pair_rst_n),
    .ramp_en    (ramp_en),
    .mode_code  (mode_code),
    .rate_tick  (rate_tick),
    .ramp_level (ramp_level),
    .sw_en      (sw_en),
    .out_hiz    (out_hiz)
  );

  // Level expected j edges after a ramp began at start (R7 arithmetic).
  function automatic int rise_at(int start, int j);
    int v = start + j / UP;
    return (v > MID) ? MID : v;
  endfunction

  function automatic int fall_at(int start, int j);
    int v = start - j / DN;
    return (v < 0) ? 0 : v;
  endfunction

  // Driver: apply inputs away from the edge, queue what the next edge must show.
  task automatic drive(input bit rs, input bit pr, input bit re, input logic [2:0] md,
                       input bit tk, input int el, input bit es, input bit eh,
                       input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = rs; pair_rst_n = pr; ramp_en = re; mode_code = md; rate_tick = tk;
    e.lvl = el; e.sw = es; e.hz = eh; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int'(ramp_level) != e.lvl || sw_en != e.sw || out_hiz != e.hz) begin
          errors++;
          $display("FAIL %s: actual lvl=%0d sw=%0b hiz=%0b expected lvl=%0d sw=%0b hiz=%0b",
                   e.tag, ramp_level, sw_en, out_hiz, e.lvl, e.sw, e.hz);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: block reset state, then stays parked while the pair is held.
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 3'd3, 0, 0, 0, 1, "R1");
    for (int i = 0; i < 2; i++) drive(1, 0, 1, 3'd3, 1, 0, 0, 1, "R1");

    // R2/R9: full rise, switching only once 512 is reached, then held there.
    for (int j = 0; j <= 1030; j++)
      drive(1, 1, 1, 3'd3, 1, rise_at(0, j), (j >= 1024), 0, (j < 1024) ? "R2" : "R9");

    // R3: full fall, high impedance only on the edge reaching 0.
    for (int j = 0; j <= 3075; j++)
      drive(1, 0, 1, 3'd3, 1, fall_at(MID, j), 0, (j >= 3072), "R3");

    // R7: no ticks, level holds at 0 while rising.
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 3'd3, 0, 0, 0, 0, "R7");
    for (int k = 1; k <= 200; k++) drive(1, 1, 1, 3'd3, 1, rise_at(0, k), 0, 0, "R7");

    // R5: reverse at 100, fall to 90, reverse again, rise back to 100.
    for (int j = 0; j <= 60; j++) drive(1, 0, 1, 3'd3, 1, fall_at(100, j), 0, 0, "R5");
    for (int j = 0; j <= 20; j++) drive(1, 1, 1, 3'd3, 1, rise_at(90, j), 0, 0, "R5");

    // R8: ramp enable dropped mid-rise jumps to switching.
    drive(1, 1, 0, 3'd3, 1, MID, 1, 0, "R8");

    // R4: immediate park and immediate run without ramping.
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 3'd3, 1, 0, 0, 1, "R4");
    for (int i = 0; i < 2; i++) drive(1, 1, 0, 3'd3, 1, MID, 1, 0, "R4");

    // R6: mode 001 and 100 ignore ramp_en; mode 111 ramps.
    drive(1, 0, 1, 3'd1, 1, 0, 0, 1, "R6");
    drive(1, 1, 1, 3'd1, 1, MID, 1, 0, "R6");
    drive(1, 1, 1, 3'd4, 1, MID, 1, 0, "R6");
    for (int j = 0; j <= 10; j++) drive(1, 0, 1, 3'd7, 1, fall_at(MID, j), 0, 0, "R6");

    // R8: ramp enable dropped mid-fall parks at once.
    drive(1, 0, 0, 3'd7, 1, 0, 0, 1, "R8");

    // R5/R3: reversal at level 0 right after release, then park.
    drive(1, 1, 1, 3'd3, 1, 0, 0, 0, "R5");
    drive(1, 0, 1, 3'd3, 1, 0, 0, 0, "R5");
    drive(1, 0, 1, 3'd3, 1, 0, 0, 1, "R3");

    // R1: block reset while switching, then recovery.
    drive(1, 1, 0, 3'd3, 1, MID, 1, 0, "R4");
    drive(0, 1, 0, 3'd3, 1, 0, 0, 1, "R1");
    drive(0, 1, 0, 3'd3, 1, 0, 0, 1, "R1");
    drive(1, 1, 0, 3'd3, 1, MID, 1, 0, "R4");

    repeat (3) @(posedge clk);
    #10;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule